// File: doc/BRIEF.md
# Three-Counter Performance Monitor

The block counts hardware events for software profiling. It holds one free-running cycle counter and two event counters. Each event counter picks its source from a vector of single-cycle event lines through an 8-bit selector. Software reaches the block through a small register port with four word addresses. Address 0 is a shared control and status word. Addresses 1 to 3 are the counters, and each one can be read and loaded.

A counter that wraps past its all-ones value sets a sticky overflow flag. Software clears a flag by writing a one back to its bit. One registered interrupt line is raised while any flag is set with its enable also set. The event counters have no enable bits of their own. To park an event counter, software selects code 0x20, which watches an external trace line that is normally held low.

Top module: `perf_monitor`

## Requirements
- R1: After reset the control word and all three counters read 0 and `irq` is low.
- R2: Control word layout at address 0. Bit 0 is the global enable. Bit 3 is the cycle prescaler enable. Bits 6:4 are the interrupt enables for event counter 0, event counter 1 and the cycle counter, in that order. Bits 10:8 are the overflow flags in the same order. Bits 27:20 are the selector for event counter 0 and bits 19:12 are the selector for event counter 1. All other bits read 0.
- R3: While bit 0 is clear, no counter changes except by a write. While bit 0 is set and the prescaler is off, the cycle counter advances by one on every clock.
- R4: While enabled, an event counter advances on each clock where `events[sel]` is high. Selector 0xFF counts every clock. A selector at or above the event vector width never counts.
- R5: A write to address 1 (cycle), 2 (event 0) or 3 (event 1) loads that counter. In the same cycle the load takes priority over any increment.
- R6: Writing 1 to control bit 1 zeroes both event counters. Writing 1 to control bit 2 zeroes the cycle counter and its prescaler. Both bits always read 0.
- R7: With bits 0 and 3 set, the cycle counter advances once every 64 clocks. The first advance comes on the 64th clock after the prescaler is turned on.
- R8: A counter that increments from all ones to zero sets its overflow flag. The flag stays set until it is cleared.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. When a clear and a new overflow land in the same cycle, the flag ends up set.
- R10: `irq` goes high one clock after any flag is set together with its interrupt enable. It goes low one clock after no such pair remains.
- R11: Selector 0x20 with `events[32]` held low holds an event counter at its value while the other counters keep running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| events | input | NUM_EVT | Event lines, sampled on each clock |
| irq | output | 1 | Registered combined overflow interrupt |

## Verification
The assertions assume that the event vector and the register port are stable around each rising clock. They also assume that a write lasts exactly one cycle per intended update. The bench drives all inputs on falling edges and releases `reg_wr` right after the capturing edge, so each write lands once. Reads are sampled at the falling edge with the write strobe low. Overflow cases are reached by loading counters near all ones rather than by waiting.

// File: rtl/perf_monitor.sv
module perf_monitor #(
  parameter int CNT_W    = 32,
  parameter int NUM_EVT  = 64,
  parameter int DIV_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] events,
  output logic               irq
);
  localparam logic [7:0] SEL_ALL = 8'hFF;
  localparam int         EXT_W   = 256;

  logic             en_q, div_q;
  logic [2:0]       ien_q, ovf_q;
  logic [7:0]       sel0_q, sel1_q;
  logic [CNT_W-1:0] cyc_q, ev0_q, ev1_q;
  logic [DIV_LOG2-1:0] pre_q;
  logic [EXT_W-1:0] ev_ext;

  assign ev_ext = {{(EXT_W-NUM_EVT){1'b0}}, events};

  wire wr_ctl = reg_wr && (reg_addr == 2'd0);
  wire wr_cyc = reg_wr && (reg_addr == 2'd1);
  wire wr_e0  = reg_wr && (reg_addr == 2'd2);
  wire wr_e1  = reg_wr && (reg_addr == 2'd3);
  wire rst_ev = wr_ctl && reg_wdata[1];
  wire rst_cy = wr_ctl && reg_wdata[2];
  wire [2:0] clr = wr_ctl ? reg_wdata[10:8] : 3'b000;

  wire hit0 = (sel0_q == SEL_ALL) || ev_ext[sel0_q];
  wire hit1 = (sel1_q == SEL_ALL) || ev_ext[sel1_q];

  wire inc_cy = en_q && (!div_q || (pre_q == '1));
  wire inc_e0 = en_q && hit0;
  wire inc_e1 = en_q && hit1;

  wire [2:0] wrap = {inc_cy && (&cyc_q) && !wr_cyc && !rst_cy,
                     inc_e1 && (&ev1_q) && !wr_e1 && !rst_ev,
                     inc_e0 && (&ev0_q) && !wr_e0 && !rst_ev};

  logic unused_ok;
  assign unused_ok = ^{reg_wdata[31:28], reg_wdata[11], reg_wdata[7]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      div_q  <= 1'b0;
      ien_q  <= '0;
      sel0_q <= '0;
      sel1_q <= '0;
    end else if (wr_ctl) begin
      en_q   <= reg_wdata[0];
      div_q  <= reg_wdata[3];
      ien_q  <= reg_wdata[6:4];
      sel0_q <= reg_wdata[27:20];
      sel1_q <= reg_wdata[19:12];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= (ovf_q & ~clr) | wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_q <= '0;
    else if (rst_cy)            pre_q <= '0;
    else if (en_q && div_q)     pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_q <= '0;
    else if (wr_cyc) cyc_q <= reg_wdata[CNT_W-1:0];
    else if (rst_cy) cyc_q <= '0;
    else if (inc_cy) cyc_q <= cyc_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ev0_q <= '0;
    else if (wr_e0)  ev0_q <= reg_wdata[CNT_W-1:0];
    else if (rst_ev) ev0_q <= '0;
    else if (inc_e0) ev0_q <= ev0_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ev1_q <= '0;
    else if (wr_e1)  ev1_q <= reg_wdata[CNT_W-1:0];
    else if (rst_ev) ev1_q <= '0;
    else if (inc_e1) ev1_q <= ev1_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(ovf_q & ien_q);
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {4'b0, sel0_q, sel1_q, 1'b0, ovf_q, 1'b0, ien_q, div_q, 2'b00, en_q};
      2'd1:    reg_rdata = 32'(cyc_q);
      2'd2:    reg_rdata = 32'(ev0_q);
      default: reg_rdata = 32'(ev1_q);
    endcase
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_cyc && !rst_cy) |=> $stable(cyc_q));
  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_e1 |=> (ev1_q == $past(reg_wdata[CNT_W-1:0])));
  // R6
  ev_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ev |=> (ev0_q == '0 && ev1_q == '0));
  // R7
  prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && div_q && (pre_q != '1) && !wr_cyc && !rst_cy) |=> $stable(cyc_q));
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((ovf_q | $past(clr)) & $past(ovf_q)) == $past(ovf_q)));
  // R10
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_q & ien_q) == 3'b000) |=> !irq);
  // R10
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ovf_q & ien_q)) |=> irq);
endmodule

// File: tb/tb_perf_monitor.sv
module tb_perf_monitor;
  localparam int NEV = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NEV-1:0] events = '0;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] v, v2;

  perf_monitor dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events(events), .irq(irq));

  always #10 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [63:0] ev;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [16] = '{
    '{1'b0, 2'd0, 32'h0,        64'h0,  4'd1},  // R1 control word
    '{1'b0, 2'd1, 32'h0,        64'h0,  4'd1},  // R1 cycle counter
    '{1'b1, 2'd2, 32'h12345678, 64'h0,  4'd5},
    '{1'b0, 2'd2, 32'h12345678, 64'h0,  4'd5},  // R5 load
    '{1'b1, 2'd0, 32'h00507071, 64'h0,  4'd2},
    '{1'b0, 2'd0, 32'h00507071, 64'h0,  4'd2},  // R2 layout
    '{1'b0, 2'd1, 32'h1,        64'h20, 4'd3},  // R3 one per clock
    '{1'b0, 2'd2, 32'h12345679, 64'hA0, 4'd4},  // R4 sel 5
    '{1'b0, 2'd3, 32'h1,        64'h0,  4'd4},  // R4 sel 7
    '{1'b0, 2'd1, 32'h4,        64'h0,  4'd3},
    '{1'b1, 2'd0, 32'h00507073, 64'h20, 4'd6},
    '{1'b0, 2'd2, 32'h0,        64'h0,  4'd6},  // R6 reset wins
    '{1'b0, 2'd0, 32'h00507071, 64'h0,  4'd6},  // R6 self-clear
    '{1'b1, 2'd0, 32'h0,        64'h0,  4'd3},
    '{1'b0, 2'd1, 32'h9,        64'h20, 4'd3},
    '{1'b0, 2'd2, 32'h0,        64'h20, 4'd3}   // R3 disabled
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1", {31'b0, irq}, 32'h0);

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      reg_wr = TBL[i].wr; reg_addr = TBL[i].addr; reg_wdata = TBL[i].data;
      events = TBL[i].ev[NEV-1:0];
      #1;
      if (!TBL[i].wr) check($sformatf("R%0d", TBL[i].req), reg_rdata, TBL[i].data);
      @(posedge clk);
      #1 reg_wr = 1'b0;
    end
    events = '0;

    // R8 R10: counter 0 wraps with select 0xFF
    wr_reg(2'd2, 32'hFFFFFFFF);
    wr_reg(2'd0, 32'h0FF00011);
    rd_reg(2'd0, v);
    rd_reg(2'd0, v);
    check("R8", v, 32'h0FF00111);
    check("R10", {31'b0, irq}, 32'h0);
    rd_reg(2'd2, v);
    check("R4", v, 32'h1);
    check("R10", {31'b0, irq}, 32'h1);

    // R11: park counter 0 on code 0x20 with the trace line low
    wr_reg(2'd0, 32'h02000011);
    rd_reg(2'd2, v);
    rd_reg(2'd2, v2);
    check("R11", v2, v);
    rd_reg(2'd0, v);
    check("R8", v, 32'h02000111);

    // R9: write-one clears, irq follows one clock later
    wr_reg(2'd0, 32'h02000111);
    rd_reg(2'd0, v);
    check("R9", v, 32'h02000011);
    rd_reg(2'd0, v);
    check("R10", {31'b0, irq}, 32'h0);

    // R9: clear and wrap in the same cycle leave the flag set
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd2, 32'hFFFFFFFF);
    wr_reg(2'd0, 32'h0FF00001);
    wr_reg(2'd0, 32'h0FF00101);
    rd_reg(2'd0, v);
    check("R9", v, 32'h0FF00101);

    // R7: prescaler
    wr_reg(2'd0, 32'h00000100);
    wr_reg(2'd1, 32'h0);
    wr_reg(2'd0, 32'h00000009);
    repeat (63) @(posedge clk);
    rd_reg(2'd1, v);
    check("R7", v, 32'h0);
    rd_reg(2'd1, v);
    check("R7", v, 32'h1);

    // R8 cycle counter wrap; R4 selector past the vector width
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'hFFFFFFFF);
    events = '1;
    wr_reg(2'd0, 32'h00050001);
    rd_reg(2'd0, v);
    rd_reg(2'd0, v);
    check("R8", v, 32'h00050401);
    rd_reg(2'd3, v);
    check("R4", v, 32'h0);
    events = '0;

    // R6 cycle counter reset bit
    wr_reg(2'd0, 32'h00000005);
    rd_reg(2'd1, v);
    check("R6", v, 32'h0);

    // R1 reset again
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", reg_rdata, 32'h0);
    check("R1", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule